// File: doc/BRIEF.md
# Masked Program-Counter Break Comparator

This block is a break-condition detector for an on-chip debug unit. It watches the processor bus one cycle at a time and compares the address of each instruction-fetch cycle against a break address held in a register. When the two agree, the block raises a break request. A mask-select field lets the comparison ignore a chosen number of low-order address bits, so one setting can cover a single location or an aligned block of up to 64 KiB. A master-select bit decides which bus owners can trigger a break. With the bit clear, only the processor can trigger one. With it set, cycles run by the transfer controller can trigger one as well.

Software loads the break address and a control byte through a small register write port. The same port reads both registers back through a select-driven read bus. The control byte holds an enable, the master select, the mask select and a sticky condition flag. A match produces a one-cycle break request on the clock after the matching cycle. The same match sets the flag, and the flag stays set until software clears it.

Top module: `pcbrk_top`

## Requirements
- R1: After reset the break address is 0, the control byte reads 0x00 (enable 0, master select 0, mask select 000, flag 0), and `brk_req` and `brk_flag` are low.
- R2: With `reg_sel`=0 a write loads all 24 bits of `reg_wdata` into the break address, and `reg_rdata` returns it. With `reg_sel`=1 a write loads control bit 7 (enable), bit 6 (master select) and bits 5:3 (mask select) from `reg_wdata[7:0]`. The control read value is `{16'h0, enable, master_sel, mask_sel, 2'b00, flag}`, so bits 2:1 and bits 23:8 always read 0.
- R3: A bus cycle counts as a match when `bus_valid`, `bus_ifetch` and enable are all 1, the bus master is permitted, and the unmasked address bits equal the break address. `brk_req` is then high for the clock cycle after the matching cycle.
- R4: Mask-select codes 0 through 7 exclude the lowest 0, 1, 2, 3, 4, 8, 12 and 16 address bits from the compare. Changing only excluded bits keeps a match. Changing the lowest included bit or bit 23 removes it.
- R5: With master select 0, a cycle with `bus_master`=1 (transfer controller) never matches. A cycle with `bus_master`=0 (processor) can match.
- R6: With master select 1, cycles from both `bus_master` values can match.
- R7: A cycle with `bus_valid`=0 or `bus_ifetch`=0 never matches.
- R8: With enable 0 no cycle matches.
- R9: A match sets the flag, which shows on `brk_flag` and in control bit 0. A control write with bit 0 = 0 clears the flag, and a write with bit 0 = 1 leaves it unchanged. If a match and a clearing write fall in the same cycle, the flag ends up set.
- R10: A single matching cycle followed by a non-matching cycle gives a `brk_req` pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 break address, 1 control |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Read data of the selected register |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | 24 | Bus cycle address |
| bus_ifetch | input | 1 | Cycle is an instruction fetch |
| bus_master | input | 1 | Bus owner: 0 processor, 1 transfer controller |
| brk_req | output | 1 | Registered break request, one cycle per match |
| brk_flag | output | 1 | Sticky break condition flag |

## Verification
The assertions take for granted that the bus presents at most one cycle per clock and that the bus inputs are settled before each rising edge. Under those conditions, an idle, non-fetch, disabled or blocked cycle can be tied directly to a low request on the next clock. The stimulus drives every bus and register input on the falling edge and holds it for one full clock. Each probe cycle is followed by an idle cycle, so each request pulse can be traced back to a single cycle.

// File: rtl/pcbrk_pkg.sv
package pcbrk_pkg;

  // Control byte bit positions
  localparam int CTL_EN_BIT    = 7;
  localparam int CTL_MSEL_BIT  = 6;
  localparam int CTL_MASK_HI   = 5;
  localparam int CTL_MASK_LO   = 3;
  localparam int CTL_FLAG_BIT  = 0;
  localparam int CTL_W         = 8;
  localparam int MASK_CODE_W   = 3;

  // Bus master identity
  localparam logic MASTER_CPU  = 1'b0;
  localparam logic MASTER_XFER = 1'b1;

  typedef struct packed {
    logic                   en;
    logic                   msel;
    logic [MASK_CODE_W-1:0] mask_code;
  } pcbrk_cfg_t;

  // Number of low address bits excluded by a mask-select code:
  // codes 0..3 step by one bit, codes 4..7 step by four bits.
  function automatic int masked_bits(input logic [MASK_CODE_W-1:0] code);
    int c;
    c = int'(code);
    if (c < 4) return c;
    return (c - 3) * 4;
  endfunction

endpackage

// File: rtl/pcbrk_regs.sv
module pcbrk_regs
  import pcbrk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              hit,
  output logic [ADDR_W-1:0] brk_addr,
  output pcbrk_cfg_t        cfg,
  output logic              flag,
  output logic [ADDR_W-1:0] reg_rdata
);

  localparam int PAD_W = ADDR_W - CTL_W;

  logic wr_addr, wr_ctl, clr_flag;
  logic [CTL_W-1:0] ctl_view;

  assign wr_addr  = reg_we && !reg_sel;
  assign wr_ctl   = reg_we &&  reg_sel;
  assign clr_flag = wr_ctl && !reg_wdata[CTL_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_addr <= '0;
      cfg      <= '0;
      flag     <= 1'b0;
    end else begin
      if (wr_addr) brk_addr <= reg_wdata;
      if (wr_ctl) begin
        cfg.en        <= reg_wdata[CTL_EN_BIT];
        cfg.msel      <= reg_wdata[CTL_MSEL_BIT];
        cfg.mask_code <= reg_wdata[CTL_MASK_HI:CTL_MASK_LO];
      end
      // hardware set wins over a software clear in the same cycle
      if (hit)           flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;
    end
  end

  always_comb begin
    ctl_view = '0;
    ctl_view[CTL_EN_BIT]               = cfg.en;
    ctl_view[CTL_MSEL_BIT]             = cfg.msel;
    ctl_view[CTL_MASK_HI:CTL_MASK_LO]  = cfg.mask_code;
    ctl_view[CTL_FLAG_BIT]             = flag;
  end

  assign reg_rdata = reg_sel ? {{PAD_W{1'b0}}, ctl_view} : brk_addr;

  // R9: a match always leaves the flag set on the next clock
  a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);

  // R9: without a clearing write the flag cannot drop
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_flag) |=> flag);

endmodule

// File: rtl/pcbrk_mask_gen.sv
module pcbrk_mask_gen
  import pcbrk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MASK_CODE_W-1:0] mask_code,
  output logic [ADDR_W-1:0]      keep_mask
);

  int n_masked;
  assign n_masked = masked_bits(mask_code);

  // one compare per address bit: bit kept when at or above the masked count
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign keep_mask[i] = (i >= n_masked);
  end

  // R4: the widest setting drops exactly the low 16 bits
  a_r4_widest_mask: assert property (@(posedge clk) disable iff (rst)
    (mask_code == 3'd7) |-> (keep_mask[15:0] == 16'h0 && &keep_mask[ADDR_W-1:16]));

  // R4: the kept region is always contiguous from the top
  a_r4_top_kept: assert property (@(posedge clk) disable iff (rst)
    keep_mask[ADDR_W-1]);

endmodule

// File: rtl/pcbrk_match.sv
module pcbrk_match
  import pcbrk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic [ADDR_W-1:0] keep_mask,
  input  pcbrk_cfg_t        cfg,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ifetch,
  input  logic              bus_master,
  output logic              hit,
  output logic              brk_req
);

  logic addr_eq, master_ok, cycle_ok;

  assign addr_eq   = ((bus_addr & keep_mask) == (brk_addr & keep_mask));
  assign master_ok = (bus_master == MASTER_CPU) || cfg.msel;
  assign cycle_ok  = bus_valid && bus_ifetch && cfg.en;
  assign hit       = cycle_ok && master_ok && addr_eq;

  always_ff @(posedge clk) begin
    if (rst) brk_req <= 1'b0;
    else     brk_req <= hit;
  end

  // R7: idle or non-fetch cycles never yield a request
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!bus_valid || !bus_ifetch) |=> !brk_req);

  // R8: a disabled comparator never yields a request
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |=> !brk_req);

  // R5: transfer-controller cycles are blocked while master select is 0
  a_r5_xfer_blocked: assert property (@(posedge clk) disable iff (rst)
    (bus_master == MASTER_XFER && !cfg.msel) |=> !brk_req);

endmodule

// File: rtl/pcbrk_top.sv
module pcbrk_top
  import pcbrk_pkg::*;
#(
  parameter int ADDR_W = 24   // must be at least 17 to hold the widest mask
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ifetch,
  input  logic              bus_master,
  output logic              brk_req,
  output logic              brk_flag
);

  logic [ADDR_W-1:0] brk_addr;
  logic [ADDR_W-1:0] keep_mask;
  pcbrk_cfg_t        cfg;
  logic              hit;

  pcbrk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .brk_addr  (brk_addr),
    .cfg       (cfg),
    .flag      (brk_flag),
    .reg_rdata (reg_rdata)
  );

  pcbrk_mask_gen #(.ADDR_W(ADDR_W)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .mask_code (cfg.mask_code),
    .keep_mask (keep_mask)
  );

  pcbrk_match #(.ADDR_W(ADDR_W)) u_match (
    .clk        (clk),
    .rst        (rst),
    .brk_addr   (brk_addr),
    .keep_mask  (keep_mask),
    .cfg        (cfg),
    .bus_valid  (bus_valid),
    .bus_addr   (bus_addr),
    .bus_ifetch (bus_ifetch),
    .bus_master (bus_master),
    .hit        (hit),
    .brk_req    (brk_req)
  );

  // R9/R10: every request pulse coincides with a set flag
  a_r10_req_implies_flag: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> brk_flag);

endmodule

// File: tb/tb_pcbrk_top.sv
module tb_pcbrk_top;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_we, reg_sel;
  logic [AW-1:0] reg_wdata, reg_rdata;
  logic          bus_valid, bus_ifetch, bus_master;
  logic [AW-1:0] bus_addr;
  logic          brk_req, brk_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  pcbrk_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_ifetch(bus_ifetch), .bus_master(bus_master),
    .brk_req(brk_req), .brk_flag(brk_flag)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input logic en, input logic ms,
                                     input logic [2:0] mc, input logic fl);
    return {en, ms, mc, 2'b00, fl};
  endfunction

  function automatic int nmask(input int code);
    return (code < 4) ? code : (code - 3) * 4;
  endfunction

  task automatic wr(input logic sel, input logic [AW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [AW-1:0] d);
    reg_sel = sel;
    #0.5;
    d = reg_rdata;
  endtask

  // one bus cycle, then check the request one clock later, then an idle cycle
  task automatic probe(input string req, input logic [AW-1:0] a, input logic m,
                       input logic v, input logic f, input logic exp);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_master = m; bus_ifetch = f;
    @(negedge clk);
    bus_valid = 1'b0; bus_ifetch = 1'b0;
    check(req, {23'd0, brk_req}, {23'd0, exp});
    @(negedge clk);
    if (exp) check("R10 pulse width", {23'd0, brk_req}, 24'd0);
  endtask

  task automatic clear_flag();
    logic [AW-1:0] r;
    rd(1'b1, r);
    wr(1'b1, {16'h0, r[7:1], 1'b0});
  endtask

  task automatic t_reset();
    logic [AW-1:0] r;
    check("R1 brk_req", {23'd0, brk_req}, 24'd0);
    check("R1 brk_flag", {23'd0, brk_flag}, 24'd0);
    rd(1'b0, r); check("R1 addr", r, 24'd0);
    rd(1'b1, r); check("R1 ctl", r, 24'd0);
  endtask

  task automatic t_readback();
    logic [AW-1:0] r;
    wr(1'b0, 24'h5A_3C_E1);
    rd(1'b0, r); check("R2 addr readback", r, 24'h5A_3C_E1);
    wr(1'b1, 24'hFF_FF_FF);   // flag clear bit written as 1: no effect while 0
    rd(1'b1, r); check("R2 ctl readback", r, 24'h00_00_F8);
    wr(1'b1, 24'h00_00_56);
    rd(1'b1, r); check("R2 ctl fields", r, {16'h0, ctl(1'b0, 1'b1, 3'd2, 1'b0)});
  endtask

  task automatic t_masks();
    logic [AW-1:0] base;
    base = 24'hA5_C3_96;
    wr(1'b0, base);
    for (int c = 0; c < 8; c++) begin
      int n;
      logic [AW-1:0] lowm;
      n = nmask(c);
      lowm = (24'd1 << n) - 24'd1;
      wr(1'b1, {16'h0, ctl(1'b1, 1'b0, 3'(c), 1'b0)});
      probe($sformatf("R4 code %0d masked bits flipped", c), base ^ lowm, 1'b0, 1'b1, 1'b1, 1'b1);
      probe($sformatf("R4 code %0d first kept bit", c), base ^ (24'd1 << n), 1'b0, 1'b1, 1'b1, 1'b0);
      probe($sformatf("R4 code %0d top bit", c), base ^ 24'h80_00_00, 1'b0, 1'b1, 1'b1, 1'b0);
    end
    clear_flag();
  endtask

  task automatic t_masters();
    wr(1'b0, 24'h00_12_34);
    wr(1'b1, {16'h0, ctl(1'b1, 1'b0, 3'd0, 1'b0)});
    probe("R5 cpu allowed", 24'h00_12_34, 1'b0, 1'b1, 1'b1, 1'b1);
    probe("R5 xfer blocked", 24'h00_12_34, 1'b1, 1'b1, 1'b1, 1'b0);
    wr(1'b1, {16'h0, ctl(1'b1, 1'b1, 3'd0, 1'b0)});
    probe("R6 cpu allowed", 24'h00_12_34, 1'b0, 1'b1, 1'b1, 1'b1);
    probe("R6 xfer allowed", 24'h00_12_34, 1'b1, 1'b1, 1'b1, 1'b1);
    probe("R3 address mismatch", 24'h00_12_35, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_qualifiers();
    probe("R7 invalid cycle", 24'h00_12_34, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R7 data cycle", 24'h00_12_34, 1'b0, 1'b1, 1'b0, 1'b0);
    wr(1'b1, {16'h0, ctl(1'b0, 1'b1, 3'd0, 1'b0)});
    probe("R8 disabled", 24'h00_12_34, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R8 flag stays clear", {23'd0, brk_flag}, 24'd0);
  endtask

  task automatic t_flag();
    logic [AW-1:0] r;
    wr(1'b1, {16'h0, ctl(1'b1, 1'b0, 3'd0, 1'b0)});
    probe("R3 hit", 24'h00_12_34, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R9 flag set", {23'd0, brk_flag}, 24'd1);
    wr(1'b1, {16'h0, ctl(1'b1, 1'b0, 3'd0, 1'b1)});
    rd(1'b1, r); check("R9 write 1 keeps flag", r, {16'h0, ctl(1'b1, 1'b0, 3'd0, 1'b1)});
    wr(1'b1, {16'h0, ctl(1'b1, 1'b0, 3'd0, 1'b0)});
    check("R9 write 0 clears flag", {23'd0, brk_flag}, 24'd0);
    // clearing write and match in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = {16'h0, ctl(1'b1, 1'b0, 3'd0, 1'b0)};
    bus_valid = 1'b1; bus_ifetch = 1'b1; bus_master = 1'b0; bus_addr = 24'h00_12_34;
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0; bus_ifetch = 1'b0;
    check("R9 set beats clear", {23'd0, brk_flag}, 24'd1);
    check("R3 request with clear", {23'd0, brk_req}, 24'd1);
  endtask

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    bus_valid = 1'b0; bus_addr = '0; bus_ifetch = 1'b0; bus_master = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_masks();
    t_masters();
    t_qualifiers();
    t_flag();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule